// File: doc/BRIEF.md
# Single/Double-Rate Output Register Stage

This block is the last storage stage between core logic and an output pin. A static mode input selects between single-rate and double-rate operation. In single-rate mode, one storage element holds the first data lane and drives the pin. A second static bit makes that element either a rising-edge flip-flop or a latch that is transparent while the clock is high.

In double-rate mode, both data lanes are registered on the rising clock edge. The registered second lane then passes through a latch that is open while the clock is low. The pin is selected directly by the clock level. The high half of each period shows the first lane and the low half shows the second lane, so each lane bit carries two values per clock. A clock enable freezes all stored state. A synchronous reset clears it.

The pin is fed straight from storage with no handshake, because the pin cannot apply back-pressure. The mode inputs are configuration. They are changed only while reset is held, and a new setting is required to take effect only once reset is released.

Top module: `oreg_out_stage`

## Requirements
- R1: With `rst` high at a rising edge, all stored data clears. In double-rate mode and in single-rate flip-flop mode, `pin_q` reads 0 in both halves of the following period. In single-rate latch mode, `pin_q` reads 0 during any high phase in which `rst` is high.
- R2: Single-rate flip-flop mode (`ddr_en`=0, `sdr_latch`=0): with `ce` high, `pin_q` takes the value of `d_first` at the rising edge and keeps it through the whole period. `d_second`, and any change of `d_first` between edges, have no effect on `pin_q`.
- R3: Single-rate latch mode (`ddr_en`=0, `sdr_latch`=1): while `clk` is high and `ce` is high, `pin_q` follows `d_first`, including changes made during the high phase.
- R4: Single-rate latch mode: while `clk` is low, `pin_q` holds the last value passed during the high phase, and changes on `d_first` are ignored.
- R5: Double-rate mode (`ddr_en`=1): with `ce` high, both `d_first` and `d_second` are captured at the rising edge. Later changes of either input within the period do not reach `pin_q`.
- R6: Double-rate mode: during the high phase after a capturing edge, `pin_q` equals the captured `d_first`. During the following low phase, it equals the captured `d_second`. The second lane is held by a latch that is open while `clk` is low.
- R7: With `ce` low at a rising edge, all stored values are kept. In flip-flop and double-rate modes, both halves of the period repeat the previous period's values. In latch mode, the latch stays closed during that high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its level also steers the double-rate output select |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable, active high |
| ddr_en | input | 1 | Static mode: 1 = double-rate, 0 = single-rate |
| sdr_latch | input | 1 | Static element select in single-rate mode: 1 = latch, 0 = flip-flop |
| d_first | input | W | Lane shown in the high phase (double-rate) or the only lane (single-rate) |
| d_second | input | W | Lane shown in the low phase in double-rate mode |
| pin_q | output | W | Value presented to the output pin |

## Verification
The bench samples `pin_q` in both halves of every period. It sweeps every pair of two-bit lane values in all three configurations, with a steady clock enable and with a pattern of enable drops, and computes each half-period value arithmetically. It changes `d_first` in the middle of every high phase and changes both lanes in the middle of every low phase. A flip-flop that leaked into transparency, or a latch that failed to open or close, would show the new value in the wrong half. A design that gated the low-phase latch with the current enable rather than relying on the held register would show stale second-lane data after an enable drop. A reset in the middle of the sweep checks that no stale second-lane value survives in the low phase.

// File: rtl/oreg_pkg.sv
`timescale 1ns/100ps
package oreg_pkg;
  typedef enum logic [1:0] {
    OM_SDR_FF    = 2'd0,
    OM_SDR_LATCH = 2'd1,
    OM_DDR       = 2'd2
  } omode_e;

  function automatic omode_e decode_mode(input logic ddr, input logic lat);
    if (ddr)      return OM_DDR;
    else if (lat) return OM_SDR_LATCH;
    else          return OM_SDR_FF;
  endfunction
endpackage

// File: rtl/oreg_edge_regs.sv
`timescale 1ns/100ps
module oreg_edge_regs #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d_a,
  input  logic [W-1:0] d_b,
  output logic [W-1:0] r_a,
  output logic [W-1:0] r_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      r_a <= '0;
      r_b <= '0;
    end else if (ce) begin
      r_a <= d_a;
      r_b <= d_b;
    end
  end
endmodule

// File: rtl/oreg_phase_latch.sv
`timescale 1ns/100ps
module oreg_phase_latch #(
  parameter int W        = 2,
  parameter bit OPEN_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic phase_ok;

  generate
    if (OPEN_HIGH) begin : g_high
      assign phase_ok = clk;
    end else begin : g_low
      assign phase_ok = ~clk;
    end
  endgenerate

  always_latch begin
    if (phase_ok && (en || clr))
      q <= clr ? '0 : d;
  end
endmodule

// File: rtl/oreg_out_stage.sv
`timescale 1ns/100ps
module oreg_out_stage
  import oreg_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         ddr_en,
  input  logic         sdr_latch,
  input  logic [W-1:0] d_first,
  input  logic [W-1:0] d_second,
  output logic [W-1:0] pin_q
);
  omode_e       mode;
  logic [W-1:0] cap_a;
  logic [W-1:0] cap_b;
  logic [W-1:0] hold_b;
  logic [W-1:0] sdr_lat_q;

  assign mode = decode_mode(ddr_en, sdr_latch);

  oreg_edge_regs #(.W(W)) u_edge (
    .clk (clk),
    .rst (rst),
    .ce  (ce),
    .d_a (d_first),
    .d_b (d_second),
    .r_a (cap_a),
    .r_b (cap_b)
  );

  // Second lane re-held during the low phase; cap_b is already frozen by ce.
  oreg_phase_latch #(.W(W), .OPEN_HIGH(1'b0)) u_hold_b (
    .clk (clk),
    .en  (1'b1),
    .clr (1'b0),
    .d   (cap_b),
    .q   (hold_b)
  );

  // Single-rate latch element, transparent in the high phase.
  oreg_phase_latch #(.W(W), .OPEN_HIGH(1'b1)) u_sdr_lat (
    .clk (clk),
    .en  (ce),
    .clr (rst),
    .d   (d_first),
    .q   (sdr_lat_q)
  );

  always_comb begin
    unique case (mode)
      OM_DDR:       pin_q = clk ? cap_a : hold_b;
      OM_SDR_LATCH: pin_q = sdr_lat_q;
      default:      pin_q = cap_a;
    endcase
  end
endmodule

// File: rtl/oreg_out_stage_chk.sv
`timescale 1ns/100ps
module oreg_out_stage_chk #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         ce,
  input logic         ddr_en,
  input logic         sdr_latch,
  input logic [W-1:0] d_first,
  input logic [W-1:0] d_second,
  input logic [W-1:0] pin_q,
  input logic [W-1:0] cap_a
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1 && (ddr_en || !sdr_latch))
      AST_RESET_ZERO: assert (pin_q == '0) else $error("pin not cleared"); // R1
  end

  AST_SDR_FF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!ddr_en && !sdr_latch && ce) |=> pin_q == $past(d_first)); // R2

  AST_SDR_LATCH_FOLLOW: assert property (@(negedge clk) disable iff (rst)
    (!ddr_en && sdr_latch && ce) |-> pin_q == d_first); // R3

  AST_DDR_CAPTURE_A: assert property (@(posedge clk) disable iff (rst)
    (ddr_en && ce) |=> cap_a == $past(d_first)); // R5

  AST_DDR_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    (ddr_en && ce) |=> pin_q == $past(d_second)); // R6

  AST_DDR_HIGH_PHASE: assert property (@(negedge clk) disable iff (rst)
    ddr_en |-> pin_q == cap_a); // R6

  AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ce && (ddr_en || !sdr_latch)) |=> $stable(pin_q)); // R7
endmodule

bind oreg_out_stage oreg_out_stage_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .ddr_en    (ddr_en),
  .sdr_latch (sdr_latch),
  .d_first   (d_first),
  .d_second  (d_second),
  .pin_q     (pin_q),
  .cap_a     (cap_a)
);

// File: tb/test_oreg_out_stage.sv
`timescale 1ns/100ps
module test_oreg_out_stage;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ce = 1'b0;
  logic         ddr_en = 1'b0;
  logic         sdr_latch = 1'b0;
  logic [W-1:0] d_first = '0;
  logic [W-1:0] d_second = '0;
  logic [W-1:0] pin_q;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  // bench model
  logic [W-1:0] m_a, m_b, m_l, prev_lo;
  bit           prev_ok = 1'b0;

  oreg_out_stage #(.W(W)) i_oreg_out_stage (
    .clk(clk), .rst(rst), .ce(ce), .ddr_en(ddr_en), .sdr_latch(sdr_latch),
    .d_first(d_first), .d_second(d_second), .pin_q(pin_q)
  );

  always #2 clk = ~clk; // 250 MHz

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: pin_q=%b expected %b (ddr=%0b lat=%0b) at %0t",
               tag, got, exp, ddr_en, sdr_latch, $time);
    end
  endtask

  function automatic string mtag(input string ff_t, input string lat_t, input string ddr_t);
    if (ddr_en) return ddr_t;
    if (sdr_latch) return lat_t;
    return ff_t;
  endfunction

  // Entered during the low phase; leaves during the next low phase.
  task automatic cycle(input logic [W-1:0] da, input logic [W-1:0] db,
                       input logic c, input logic r);
    d_first = da; d_second = db; ce = c; rst = r;
    #0.5;
    if (prev_ok) check(mtag("R2", "R4", "R5"), pin_q, prev_lo);
    @(posedge clk);
    if (r) begin m_a = '0; m_b = '0; end
    else if (c) begin m_a = da; m_b = db; end
    if (sdr_latch && !ddr_en && (c || r)) m_l = r ? '0 : da;
    #1;
    if (r) check(mtag("R1", "R1", "R1"),
                 pin_q, (ddr_en || !sdr_latch) ? m_a : m_l);
    else if (ddr_en) check("R6", pin_q, m_a);
    else if (sdr_latch) check(c ? "R3" : "R7", pin_q, m_l);
    else check(c ? "R2" : "R7", pin_q, m_a);
    d_first = ~da;
    #0.5;
    if (sdr_latch && !ddr_en && (c || r)) m_l = r ? '0 : ~da;
    check(mtag("R2", "R3", "R5"), pin_q, (ddr_en || !sdr_latch) ? m_a : m_l);
    @(negedge clk);
    #1;
    prev_lo = ddr_en ? m_b : (sdr_latch ? m_l : m_a);
    check(r ? "R1" : mtag(c ? "R2" : "R7", "R4", c ? "R6" : "R7"), pin_q, prev_lo);
    prev_ok = 1'b1;
  endtask

  initial begin
    @(negedge clk); #1;
    for (int m = 0; m < 3; m++) begin
      prev_ok = 1'b0;
      rst = 1'b1;
      ddr_en = (m == 2);
      sdr_latch = (m == 1);
      m_l = '0;
      cycle(2'b11, 2'b10, 1'b1, 1'b1);
      cycle(2'b01, 2'b11, 1'b0, 1'b1);
      for (int pass = 0; pass < 2; pass++) begin
        for (int v = 0; v < 16; v++) begin
          logic [3:0] vv;
          vv = 4'(v);
          cycle(vv[1:0], vv[3:2], (pass == 0) ? 1'b1 : ((v % 3) != 0), 1'b0);
        end
      end
      cycle(2'b10, 2'b01, 1'b1, 1'b0);
      cycle(2'b11, 2'b11, 1'b1, 1'b1);   // mid-run reset (R1)
      cycle(2'b01, 2'b10, 1'b1, 1'b0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule